// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects the interrupt requests that a CPU core must service. The sources are a parameterized set of maskable peripheral requests, one external maskable request pin and one external non-maskable pin. It picks the winning pending request and presents it to the core. The output is a request level together with the vector address of the chosen service routine. The core takes a new request only at an instruction boundary. It confirms the hand-over with an acknowledge pulse and later signals the end of the service routine with a return pulse.

Priority follows the vector address: a higher address wins. Every source owns a fixed vector. The non-maskable pin has `0xFFF4`. The external maskable pin has `0xFFF2`. Peripheral `k` (counting from 0) has `0xFFF0 - 2*k`. A promotion register holds one low byte. When that byte equals the low byte of a maskable source's vector, that source rises above every other maskable source.

The block owns the two mask bits of the core's condition register: the global maskable-interrupt mask and the non-maskable enable bit. It updates both on entry to service. It restores both on return, using a small save stack. Software can lower the non-maskable bit but can never raise it.

Top module: `irq_prio_ctl`

## Requirements
- R1: A maskable source can win only while its local enable is 1 and the global mask `imask_o` is 0. A pending source that lacks either condition never raises `irq_o`.
- R2: Among eligible maskable sources, the one with the highest vector wins. The vectors are `0xFFF2` for the external pin and `0xFFF0 - 2*k` for peripheral k.
- R3: The promotion register resets to `0xF2`. Writing it with the low byte of an eligible maskable source's vector makes that source win over all other maskable sources. A byte that matches no source leaves the order of R2 in force.
- R4: With `ext_edge_i` = 0, the external pin requests while it is low and stops requesting once it is high. No state is kept.
- R5: With `ext_edge_i` = 1, a falling edge on the external pin records a pending request. The record holds after the pin returns high and is cleared when the `0xFFF2` vector is acknowledged. A pin held low afterwards raises no second request.
- R6: `irq_o` rises only in the cycle after `boundary_i` was 1 with an eligible request.
- R7: `xmask_o` is 1 after reset. A software write can clear it. A software write can never set it.
- R8: Acknowledging the non-maskable vector sets both `xmask_o` and `imask_o`. The matching return pulse `rti_i` restores both bits to their values before entry.
- R9: An active-low `nmi_n_i` with `xmask_o` = 0 wins with vector `0xFFF4` over every maskable source, whatever the promotion register holds. While `xmask_o` = 1 it raises no request.
- R10: From the cycle `irq_o` rises until the cycle after `ack_i`, `irq_o` stays 1 and `vec_o` does not change.
- R11: Acknowledging a maskable vector sets `imask_o` and leaves `xmask_o` alone. `rti_i` restores the bits saved at that entry.
- R12: After reset, `irq_o` = 0, `vec_o` = 0, `imask_o` = 1 and `xmask_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_req_i | input | NUM_PERIPH | Peripheral request levels, bit k is peripheral k |
| periph_en_i | input | NUM_PERIPH | Local enables of the peripheral requests |
| ext_irq_n_i | input | 1 | External maskable request pin, active low |
| ext_en_i | input | 1 | Local enable of the external pin |
| ext_edge_i | input | 1 | 1 selects falling-edge mode, 0 selects low-level mode |
| nmi_n_i | input | 1 | Non-maskable request pin, active low |
| prom_we_i | input | 1 | Write strobe of the promotion register |
| prom_data_i | input | 8 | Vector low byte written into the promotion register |
| ccr_we_i | input | 1 | Software write strobe of the mask bits |
| ccr_x_i | input | 1 | Written value of the non-maskable bit (can only clear it) |
| ccr_i_i | input | 1 | Written value of the global mask bit |
| boundary_i | input | 1 | Current instruction completes this cycle |
| ack_i | input | 1 | Core acknowledges the presented vector |
| rti_i | input | 1 | Core returns from a service routine |
| irq_o | output | 1 | Request presented to the core |
| vec_o | output | 16 | Vector address of the presented request |
| xmask_o | output | 1 | Non-maskable enable bit (1 = disabled) |
| imask_o | output | 1 | Global maskable-interrupt mask |

## Verification
The properties assume that the core sends `ack_i` and `rti_i` as single-cycle pulses. They also assume that `ack_i` arrives only while a request is presented and that every `rti_i` pairs with an earlier acknowledge. Software writes to the mask bits are assumed not to coincide with either pulse. The stimulus respects these conditions by construction. Each trial raises the boundary for one cycle, acknowledges only when a request appeared, returns exactly once per acknowledge, and makes software writes only while no service is open. Random trials keep the external pin in level mode so that no edge record carries from one trial to the next. Edge mode is exercised only in directed cases.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int unsigned VEC_W = 16;

  // fixed vector of the non-maskable pin, above every maskable vector
  localparam logic [VEC_W-1:0] NMI_VEC = 16'hFFF4;
  // maskable index 0 is the external pin; index j has vector TOP - 2*j
  localparam logic [VEC_W-1:0] MSK_TOP_VEC = 16'hFFF2;

  function automatic logic [VEC_W-1:0] msk_vec(input int unsigned j);
    return MSK_TOP_VEC - VEC_W'(2 * j);
  endfunction

  function automatic logic [7:0] msk_low(input int unsigned j);
    logic [VEC_W-1:0] v;
    v = msk_vec(j);
    return v[7:0];
  endfunction

endpackage

// File: rtl/irq_prio_pin.sv
module irq_prio_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic req_o
);

  logic prev_q, prev_d;
  logic held_q, held_d;
  logic fall;

  always_comb begin
    fall   = prev_q & ~pin_n_i;
    prev_d = pin_n_i;
    // edge record only exists in edge mode; a new edge beats a clear
    held_d = edge_mode_i & ((held_q & ~clr_i) | fall);
    req_o  = edge_mode_i ? held_q : ~pin_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      held_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      held_q <= held_d;
    end
  end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_MSK = 7
) (
  input  logic [N_MSK-1:0] elig_i,
  input  logic             nmi_act_i,
  input  logic [7:0]       prom_i,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam int unsigned IDX_W = (N_MSK > 1) ? $clog2(N_MSK) : 1;

  logic [N_MSK-1:0] prom_hit;
  logic [IDX_W-1:0] sel;

  // one comparator per maskable source against the promotion byte
  genvar g;
  generate
    for (g = 0; g < N_MSK; g++) begin : g_hit
      assign prom_hit[g] = elig_i[g] & (prom_i == msk_low(g));
    end
  endgenerate

  always_comb begin
    sel = '0;
    // lowest index means highest vector
    for (int j = N_MSK - 1; j >= 0; j--) begin
      if (elig_i[j]) sel = IDX_W'(j);
    end
    for (int j = 0; j < N_MSK; j++) begin
      if (prom_hit[j]) sel = IDX_W'(j);
    end
    any_o = nmi_act_i | (|elig_i);
    vec_o = nmi_act_i ? NMI_VEC : msk_vec(int'(sel));
  end

endmodule

// File: rtl/irq_prio_ccr.sv
module irq_prio_ccr #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic enter_nmi_i,
  input  logic rti_i,
  input  logic sw_we_i,
  input  logic sw_x_i,
  input  logic sw_i_i,
  output logic x_o,
  output logic i_o
);

  localparam int unsigned PTR_W = $clog2(DEPTH + 1);

  logic             x_q, x_d, i_q, i_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [1:0]       stk_q [DEPTH];
  logic [1:0]       stk_d [DEPTH];

  always_comb begin
    x_d   = x_q;
    i_d   = i_q;
    ptr_d = ptr_q;
    stk_d = stk_q;
    if (enter_i) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (ptr_q == PTR_W'(k)) begin
          stk_d[k] = {x_q, i_q};
          ptr_d    = PTR_W'(k + 1);
        end
      end
      i_d = 1'b1;
      if (enter_nmi_i) x_d = 1'b1;
    end else if (rti_i) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (ptr_q == PTR_W'(k + 1)) begin
          {x_d, i_d} = stk_q[k];
          ptr_d      = PTR_W'(k);
        end
      end
    end else if (sw_we_i) begin
      x_d = x_q & sw_x_i;   // software may only lower this bit
      i_d = sw_i_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= 1'b1;
      i_q   <= 1'b1;
      ptr_q <= '0;
      for (int k = 0; k < DEPTH; k++) stk_q[k] <= 2'b00;
    end else begin
      x_q   <= x_d;
      i_q   <= i_d;
      ptr_q <= ptr_d;
      stk_q <= stk_d;
    end
  end

  assign x_o = x_q;
  assign i_o = i_q;

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 6,
  parameter int unsigned SAVE_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  input  logic [NUM_PERIPH-1:0] periph_en_i,
  input  logic                  ext_irq_n_i,
  input  logic                  ext_en_i,
  input  logic                  ext_edge_i,
  input  logic                  nmi_n_i,
  input  logic                  prom_we_i,
  input  logic [7:0]            prom_data_i,
  input  logic                  ccr_we_i,
  input  logic                  ccr_x_i,
  input  logic                  ccr_i_i,
  input  logic                  boundary_i,
  input  logic                  ack_i,
  input  logic                  rti_i,
  output logic                  irq_o,
  output logic [15:0]           vec_o,
  output logic                  xmask_o,
  output logic                  imask_o
);

  localparam int unsigned N_MSK    = NUM_PERIPH + 1;
  localparam logic [7:0]  PROM_RST = msk_low(0);

  logic             ext_req, ext_clr;
  logic [N_MSK-1:0] msk_req, elig;
  logic             nmi_act, any_req;
  logic [VEC_W-1:0] sel_vec;
  logic [7:0]       prom_q, prom_d;
  logic             pres_q, pres_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             take, accept, accept_nmi;
  logic             x_bit, i_bit;

  irq_prio_pin u_pin (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_n_i     (ext_irq_n_i),
    .edge_mode_i (ext_edge_i),
    .clr_i       (ext_clr),
    .req_o       (ext_req)
  );

  assign msk_req = {periph_req_i & periph_en_i, ext_req & ext_en_i};
  assign elig    = msk_req & {N_MSK{~i_bit}};
  assign nmi_act = ~nmi_n_i & ~x_bit;

  irq_prio_arb #(.N_MSK(N_MSK)) u_arb (
    .elig_i    (elig),
    .nmi_act_i (nmi_act),
    .prom_i    (prom_q),
    .any_o     (any_req),
    .vec_o     (sel_vec)
  );

  always_comb begin
    take       = ~pres_q & boundary_i & any_req;
    accept     = pres_q & ack_i;
    accept_nmi = accept & (vec_q == NMI_VEC);
    ext_clr    = accept & (vec_q == MSK_TOP_VEC);
    pres_d     = take | (pres_q & ~ack_i);
    vec_d      = take ? sel_vec : vec_q;
    prom_d     = prom_we_i ? prom_data_i : prom_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= 1'b0;
      vec_q  <= '0;
      prom_q <= PROM_RST;
    end else begin
      pres_q <= pres_d;
      vec_q  <= vec_d;
      prom_q <= prom_d;
    end
  end

  irq_prio_ccr #(.DEPTH(SAVE_DEPTH)) u_ccr (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_i     (accept),
    .enter_nmi_i (accept_nmi),
    .rti_i       (rti_i),
    .sw_we_i     (ccr_we_i),
    .sw_x_i      (ccr_x_i),
    .sw_i_i      (ccr_i_i),
    .x_o         (x_bit),
    .i_o         (i_bit)
  );

  assign irq_o   = pres_q;
  assign vec_o   = vec_q;
  assign xmask_o = x_bit;
  assign imask_o = i_bit;

endmodule

// File: rtl/irq_prio_ctl_chk.sv
module irq_prio_ctl_chk
  import irq_prio_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        boundary_i,
  input logic        ack_i,
  input logic        rti_i,
  input logic        nmi_n_i,
  input logic        irq_o,
  input logic [15:0] vec_o,
  input logic        xmask_o,
  input logic        imask_o
);

  // R10
  held_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  // R6
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(boundary_i));

  // R1
  imask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && vec_o != NMI_VEC) |-> !$past(imask_o));

  // R9
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && vec_o == NMI_VEC) |-> !$past(xmask_o));

  // R9
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && $past(!nmi_n_i && !xmask_o)) |-> (vec_o == NMI_VEC));

  // R8
  nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i && vec_o == NMI_VEC) |=> (xmask_o && imask_o));

  // R11
  msk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> imask_o);

  // R7
  x_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmask_o) |-> ($past(irq_o && ack_i && vec_o == NMI_VEC) || $past(rti_i)));

endmodule

bind irq_prio_ctl irq_prio_ctl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary_i (boundary_i),
  .ack_i      (ack_i),
  .rti_i      (rti_i),
  .nmi_n_i    (nmi_n_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .xmask_o    (xmask_o),
  .imask_o    (imask_o)
);

// File: tb/irq_prio_ctl_tb_top.sv
module irq_prio_ctl_tb_top;

  localparam int NP = 6;
  localparam int NM = NP + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] periph_req, periph_en;
  logic          ext_irq_n, ext_en, ext_edge, nmi_n;
  logic          prom_we;
  logic [7:0]    prom_data;
  logic          ccr_we, ccr_x, ccr_i;
  logic          boundary, ack, rti;
  logic          irq;
  logic [15:0]   vec;
  logic          xmask, imask;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_prio_ctl #(.NUM_PERIPH(NP), .SAVE_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .periph_req_i(periph_req), .periph_en_i(periph_en),
    .ext_irq_n_i(ext_irq_n), .ext_en_i(ext_en), .ext_edge_i(ext_edge),
    .nmi_n_i(nmi_n), .prom_we_i(prom_we), .prom_data_i(prom_data),
    .ccr_we_i(ccr_we), .ccr_x_i(ccr_x), .ccr_i_i(ccr_i),
    .boundary_i(boundary), .ack_i(ack), .rti_i(rti),
    .irq_o(irq), .vec_o(vec), .xmask_o(xmask), .imask_o(imask)
  );

  function automatic logic [15:0] vec_of(input int j);
    return 16'hFFF2 - 16'(2 * j);
  endfunction

  // expected {present, vector} from the priority rules
  function automatic logic [16:0] model_pick(input logic [NM-1:0] el,
                                              input logic nmi_on,
                                              input logic [7:0] pb);
    logic [15:0] v;
    if (nmi_on) return {1'b1, 16'hFFF4};
    for (int j = 0; j < NM; j++) begin
      v = vec_of(j);
      if (el[j] && pb == v[7:0]) return {1'b1, v};
    end
    for (int j = 0; j < NM; j++) if (el[j]) return {1'b1, vec_of(j)};
    return 17'd0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ccr(input logic x, input logic i);
    ccr_we = 1'b1; ccr_x = x; ccr_i = i;
    step();
    ccr_we = 1'b0;
  endtask

  task automatic wr_prom(input logic [7:0] b);
    prom_we = 1'b1; prom_data = b;
    step();
    prom_we = 1'b0;
  endtask

  task automatic try_take(input string req, input logic exp_irq, input logic [15:0] exp_vec);
    boundary = 1'b1;
    step();
    boundary = 1'b0;
    chk(req, "irq", 32'(irq), 32'(exp_irq));
    if (exp_irq) chk(req, "vec", 32'(vec), 32'(exp_vec));
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic do_rti();
    rti = 1'b1;
    step();
    rti = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [16:0]   pick;
    logic [NM-1:0] el;
    logic [15:0]   hold_v;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    periph_req = '0; periph_en = '0;
    ext_irq_n = 1'b1; ext_en = 1'b0; ext_edge = 1'b0; nmi_n = 1'b1;
    prom_we = 1'b0; prom_data = '0;
    ccr_we = 1'b0; ccr_x = 1'b1; ccr_i = 1'b1;
    boundary = 1'b0; ack = 1'b0; rti = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R12 reset state
    chk("R12", "irq", 32'(irq), 0);
    chk("R12", "vec", 32'(vec), 0);
    chk("R12", "xmask", 32'(xmask), 1);
    chk("R12", "imask", 32'(imask), 1);

    // R1 global mask blocks an enabled source
    periph_req[0] = 1'b1; periph_en[0] = 1'b1;
    try_take("R1", 1'b0, 16'h0);
    // R1 local enable blocks with the global mask clear
    wr_ccr(1'b1, 1'b0);
    chk("R7", "xmask kept", 32'(xmask), 1);
    periph_en[0] = 1'b0;
    try_take("R1", 1'b0, 16'h0);

    // R7 software clears X, then cannot set it
    wr_ccr(1'b0, 1'b0);
    chk("R7", "xmask cleared", 32'(xmask), 0);
    wr_ccr(1'b1, 1'b0);
    chk("R7", "xmask stays clear", 32'(xmask), 0);

    // R6 no request without a boundary
    periph_en[0] = 1'b1;
    repeat (3) begin
      step();
      chk("R6", "irq without boundary", 32'(irq), 0);
    end
    try_take("R6", 1'b1, 16'hFFF0);
    do_ack();
    chk("R11", "imask on entry", 32'(imask), 1);
    chk("R11", "xmask untouched", 32'(xmask), 0);
    do_rti();
    chk("R11", "imask restored", 32'(imask), 0);

    // R2 and R10 several pending peripherals, long hold
    periph_req = '1; periph_en = 6'b111110;
    try_take("R2", 1'b1, 16'hFFEE);
    hold_v = vec;
    periph_req = 6'b000010;
    repeat (3) begin
      step();
      chk("R10", "irq held", 32'(irq), 1);
      chk("R10", "vec held", 32'(vec), 32'(hold_v));
    end
    do_ack();
    chk("R10", "irq dropped after ack", 32'(irq), 0);
    do_rti();

    // R3 promotion reset value, promoted peripheral, unmatched byte
    periph_req = '1; periph_en = '1;
    ext_en = 1'b1; ext_irq_n = 1'b0;
    try_take("R3", 1'b1, 16'hFFF2);
    do_ack(); do_rti();
    wr_prom(8'hEA);
    try_take("R3", 1'b1, 16'hFFEA);
    do_ack(); do_rti();
    wr_prom(8'h13);
    try_take("R3", 1'b1, 16'hFFF2);
    do_ack(); do_rti();

    // R9 NMI beats a promoted source, then is masked by X
    wr_prom(8'hEA);
    nmi_n = 1'b0;
    try_take("R9", 1'b1, 16'hFFF4);
    do_ack();
    chk("R8", "xmask on entry", 32'(xmask), 1);
    chk("R8", "imask on entry", 32'(imask), 1);
    try_take("R9", 1'b0, 16'h0);
    do_rti();
    chk("R8", "xmask restored", 32'(xmask), 0);
    chk("R8", "imask restored", 32'(imask), 0);
    nmi_n = 1'b1;

    // R4 level mode follows the pin
    periph_req = '0;
    try_take("R4", 1'b1, 16'hFFF2);
    do_ack(); do_rti();
    ext_irq_n = 1'b1;
    try_take("R4", 1'b0, 16'h0);

    // R5 edge mode: a short low pulse is remembered
    ext_edge = 1'b1;
    step();
    ext_irq_n = 1'b0;
    step();
    ext_irq_n = 1'b1;
    step(); step();
    try_take("R5", 1'b1, 16'hFFF2);
    do_ack(); do_rti();
    try_take("R5", 1'b0, 16'h0);
    // R5 a pin held low raises only one request
    ext_irq_n = 1'b0;
    step();
    try_take("R5", 1'b1, 16'hFFF2);
    do_ack(); do_rti();
    step();
    try_take("R5", 1'b0, 16'h0);
    ext_irq_n = 1'b1; ext_edge = 1'b0;
    step();

    // random trials, external pin in level mode, X clear, I clear
    for (int t = 0; t < 150; t++) begin
      periph_req = NP'($urandom);
      periph_en  = NP'($urandom);
      ext_en     = 1'($urandom);
      ext_irq_n  = 1'($urandom);
      nmi_n      = ($urandom % 6) != 0;
      if ($urandom % 2) begin
        pick = 17'(vec_of(int'($urandom % NM)));
        wr_prom(pick[7:0]);
      end else begin
        wr_prom(8'($urandom));
      end
      el = {periph_req & periph_en, ext_en & ~ext_irq_n};
      pick = model_pick(el, ~nmi_n, dut_i.prom_q);
      try_take("R2", pick[16], pick[15:0]);
      if (pick[16]) begin
        do_ack();
        chk("R11", "imask on entry", 32'(imask), 1);
        chk("R8", "xmask on entry", 32'(xmask), 32'(pick[15:0] == 16'hFFF4));
        do_rti();
        chk("R8", "xmask restored", 32'(xmask), 0);
        chk("R11", "imask restored", 32'(imask), 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule